// File: doc/BRIEF.md
# USB Endpoint Transaction Status Recorder

This block keeps the outcome of the most recent transaction on one USB device endpoint. A packet engine sends it single-cycle event pulses: the start of a transaction (a token, with its kind), the end of a received data packet (toggle, CRC verdict, packet-type verdict, byte length), the end of a transmitted IN data packet, and an ACK handshake. From these pulses, and from the endpoint's enable, direction and arm controls and its programmed byte count, the block sets a set of status flags. It also computes a signed count difference.

Errors and length mismatches are kept apart. A bad CRC or an unexpected packet type is an error. A packet that is shorter or longer than programmed raises a length exception with a separate overflow or underflow indication, and never an error. SETUP data is taken whenever the endpoint is enabled, whatever the arm and direction controls say. A down-counter watches for a missing handshake after IN data and for a missing data stage after an OUT token. Software reads both registers through a small port. It clears status flags by writing ones, and it may load the count-result register.

Top module: `ep_xact_recorder`

## Requirements
- R1: A data packet that is accepted and reports a CRC failure or an unexpected packet type sets the error flag, status bit 1, one cycle after the packet pulse.
- R2: Each accepted data packet overwrites the error flag with its own CRC and packet-type verdict, so a length mismatch alone leaves the error flag at 0.
- R3: For an accepted non-SETUP data packet, status bit 9 is the length exception flag (length differs from the programmed count). Bit 11 is set when more bytes arrived than programmed (overflow), and bit 10 when fewer arrived (underflow). Bits 10 and 11 are never both 1.
- R4: For an accepted non-SETUP data packet, the count-result register becomes the programmed count minus the received length, as a 16-bit two's-complement value. It holds that value until the next such packet or a software write.
- R5: Status bit 3 records the toggle of the last accepted data packet: 1 for DATA1 and 0 for DATA0. A toggle value never causes a packet to be rejected.
- R6: A data packet after a SETUP token (tok_kind 2) is accepted whenever cfg_en is 1, whatever the values of cfg_arm and cfg_dir. It sets status bit 4 when it carries no error, and it changes neither the length flags nor the count result.
- R7: A data packet after an OUT token (tok_kind 0) is accepted only when cfg_en=1, cfg_arm=1 and cfg_dir=0. Any packet that is not accepted leaves the status and the count result unchanged.
- R8: After evt_tx_done during an IN transaction (tok_kind 1) with cfg_en=1, cfg_arm=1 and cfg_dir=1, the timeout flag (status bit 2) is set TO_CYCLES cycles later if no evt_ack, evt_rx or evt_token arrives in between.
- R9: After an OUT token with cfg_en=1, cfg_arm=1 and cfg_dir=0, the timeout flag is set TO_CYCLES cycles later if no data packet arrives in between.
- R10: evt_ack with cfg_en=1 sets the ACK flag (status bit 0). It also stops a running timeout window.
- R11: evt_token clears every status bit on the next cycle, and this takes priority over all other events in that cycle. The count result is kept.
- R12: A write to address 0 clears each status bit whose write-data bit is 1. A write to address 1 loads the count result. A hardware update in the same cycle takes priority over either write.
- R13: reg_rdata shows the status (address 0) or the count result (address 1) one cycle after the address is presented. All registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Endpoint enable |
| cfg_dir | input | 1 | Direction select: 1 = IN, 0 = OUT |
| cfg_arm | input | 1 | Endpoint armed for a data transfer |
| cfg_count | input | CNT_W | Programmed byte count |
| evt_token | input | 1 | Transaction start pulse |
| tok_kind | input | 2 | Token kind: 0 OUT, 1 IN, 2 SETUP, 3 none |
| evt_rx | input | 1 | Received data packet end pulse |
| rx_data1 | input | 1 | Received packet toggle is DATA1 |
| rx_crc_bad | input | 1 | CRC5 or CRC16 check failed |
| rx_pid_bad | input | 1 | Unexpected packet type |
| rx_len | input | CNT_W | Received byte length |
| evt_tx_done | input | 1 | Transmitted IN data packet end pulse |
| evt_ack | input | 1 | ACK handshake pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 status, 1 count result |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |

## Verification
The key collision is a hardware flag update and a software write-one-to-clear of the same flag in the same cycle. The bench provokes it by driving a CRC-failing packet on the very cycle that clears the error bit, and expects the error flag to remain set. It checks the same kind of priority for a count-result write that lands on the cycle of an accepted packet, and for a token arriving while a timeout window runs. Each case is judged by reading the registers back after the event and comparing them with values the bench computes from the requirements.

// File: rtl/ep_xact_pkg.sv
package ep_xact_pkg;
  localparam int ST_W  = 16;
  localparam int B_ACK = 0;
  localparam int B_ERR = 1;
  localparam int B_TMO = 2;
  localparam int B_SEQ = 3;
  localparam int B_SUP = 4;
  localparam int B_LEX = 9;
  localparam int B_UNF = 10;
  localparam int B_OVF = 11;

  typedef enum logic [1:0] {
    TK_OUT   = 2'd0,
    TK_IN    = 2'd1,
    TK_SETUP = 2'd2,
    TK_NONE  = 2'd3
  } tok_kind_e;
endpackage

// File: rtl/ep_tmo_timer.sv
module ep_tmo_timer #(
  parameter int TO_CYCLES = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic stop,
  output logic expire
);
  localparam int TW = $clog2(TO_CYCLES + 1);

  logic [TW-1:0] cnt;
  logic          run;

  assign expire = run && (cnt == TW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (load) begin
      run <= 1'b1;
      cnt <= TW'(TO_CYCLES);
    end else if (stop || expire) begin
      run <= 1'b0;
    end else if (run) begin
      cnt <= cnt - TW'(1);
    end
  end
endmodule

// File: rtl/ep_flag_engine.sv
module ep_flag_engine
  import ep_xact_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_en,
  input  logic             cfg_dir,
  input  logic             cfg_arm,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             evt_token,
  input  tok_kind_e        tok_kind,
  input  logic             evt_rx,
  input  logic             rx_data1,
  input  logic             rx_crc_bad,
  input  logic             rx_pid_bad,
  input  logic [CNT_W-1:0] rx_len,
  input  logic             evt_ack,
  input  logic             tmo_expire,
  input  logic [ST_W-1:0]  clr_mask,
  input  logic             res_we,
  input  logic [ST_W-1:0]  res_wdata,
  output logic             rx_accept,
  output tok_kind_e        kind_q,
  output logic [ST_W-1:0]  status_q,
  output logic [ST_W-1:0]  result_q
);
  logic [ST_W-1:0] st_n;
  logic            pkt_err;
  logic            is_setup;
  logic [ST_W-1:0] diff;

  assign is_setup  = (kind_q == TK_SETUP);
  assign rx_accept = evt_rx && cfg_en &&
                     (is_setup || (kind_q == TK_OUT && cfg_arm && !cfg_dir));
  assign pkt_err   = rx_crc_bad || rx_pid_bad;
  assign diff      = ST_W'(cfg_count) - ST_W'(rx_len);

  always_comb begin
    st_n = status_q & ~clr_mask;
    if (tmo_expire)        st_n[B_TMO] = 1'b1;
    if (evt_ack && cfg_en) st_n[B_ACK] = 1'b1;
    if (rx_accept) begin
      st_n[B_ERR] = pkt_err;
      st_n[B_SEQ] = rx_data1;
      if (is_setup) begin
        st_n[B_SUP] = !pkt_err;
      end else begin
        st_n[B_LEX] = (rx_len != cfg_count);
        st_n[B_OVF] = (rx_len > cfg_count);
        st_n[B_UNF] = (rx_len < cfg_count);
      end
    end
    if (evt_token) st_n = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      result_q <= '0;
      kind_q   <= TK_NONE;
    end else begin
      status_q <= st_n;
      if (evt_token) kind_q <= tok_kind;
      if (rx_accept && !is_setup) result_q <= diff;
      else if (res_we)            result_q <= res_wdata;
    end
  end
endmodule

// File: rtl/ep_reg_port.sv
module ep_reg_port
  import ep_xact_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_we,
  input  logic            reg_addr,
  input  logic [ST_W-1:0] reg_wdata,
  input  logic [ST_W-1:0] status_q,
  input  logic [ST_W-1:0] result_q,
  output logic [ST_W-1:0] clr_mask,
  output logic            res_we,
  output logic [ST_W-1:0] reg_rdata
);
  assign clr_mask = (reg_we && !reg_addr) ? reg_wdata : '0;
  assign res_we   = reg_we && reg_addr;

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= reg_addr ? result_q : status_q;
  end
endmodule

// File: rtl/ep_xact_recorder.sv
module ep_xact_recorder
  import ep_xact_pkg::*;
#(
  parameter int CNT_W     = 10,
  parameter int TO_CYCLES = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_en,
  input  logic             cfg_dir,
  input  logic             cfg_arm,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             evt_token,
  input  logic [1:0]       tok_kind,
  input  logic             evt_rx,
  input  logic             rx_data1,
  input  logic             rx_crc_bad,
  input  logic             rx_pid_bad,
  input  logic [CNT_W-1:0] rx_len,
  input  logic             evt_tx_done,
  input  logic             evt_ack,
  input  logic             reg_we,
  input  logic             reg_addr,
  input  logic [15:0]      reg_wdata,
  output logic [15:0]      reg_rdata
);
  tok_kind_e       kind_q;
  tok_kind_e       tok_in;
  logic            rx_accept;
  logic            tmo_expire;
  logic            tmo_load;
  logic            tmo_stop;
  logic [ST_W-1:0] status_q;
  logic [ST_W-1:0] result_q;
  logic [ST_W-1:0] clr_mask;
  logic            res_we;

  assign tok_in   = tok_kind_e'(tok_kind);
  assign tmo_load = (evt_token && tok_in == TK_OUT && cfg_en && cfg_arm && !cfg_dir) ||
                    (evt_tx_done && kind_q == TK_IN && cfg_en && cfg_arm && cfg_dir);
  assign tmo_stop = evt_rx || evt_ack || evt_token;

  ep_tmo_timer #(.TO_CYCLES(TO_CYCLES)) u_tmo (
    .clk(clk), .rst(rst), .load(tmo_load), .stop(tmo_stop), .expire(tmo_expire)
  );

  ep_flag_engine #(.CNT_W(CNT_W)) u_flags (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_dir(cfg_dir), .cfg_arm(cfg_arm),
    .cfg_count(cfg_count), .evt_token(evt_token), .tok_kind(tok_in),
    .evt_rx(evt_rx), .rx_data1(rx_data1), .rx_crc_bad(rx_crc_bad),
    .rx_pid_bad(rx_pid_bad), .rx_len(rx_len), .evt_ack(evt_ack),
    .tmo_expire(tmo_expire), .clr_mask(clr_mask), .res_we(res_we),
    .res_wdata(reg_wdata), .rx_accept(rx_accept), .kind_q(kind_q),
    .status_q(status_q), .result_q(result_q)
  );

  ep_reg_port u_port (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .status_q(status_q), .result_q(result_q),
    .clr_mask(clr_mask), .res_we(res_we), .reg_rdata(reg_rdata)
  );
endmodule

// File: rtl/ep_xact_recorder_chk.sv
module ep_xact_recorder_chk (
  input logic        clk,
  input logic        rst,
  input logic        cfg_en,
  input logic        evt_token,
  input logic        evt_rx,
  input logic        rx_crc_bad,
  input logic        rx_pid_bad,
  input logic        evt_ack,
  input logic        reg_we,
  input logic        reg_addr,
  input logic        rx_accept,
  input logic        tmo_expire,
  input logic [15:0] status_q,
  input logic [15:0] reg_rdata
);
  // R1
  err_set_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_accept && (rx_crc_bad || rx_pid_bad) && !evt_token) |=> status_q[1]);
  // R2
  no_len_err_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_accept && !rx_crc_bad && !rx_pid_bad && !evt_token) |=> !status_q[1]);
  // R3
  ovf_unf_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(status_q[11] && status_q[10]));
  // R7
  disabled_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_rx && !cfg_en && !evt_token && !reg_we && !evt_ack && !tmo_expire)
    |=> $stable(status_q));
  // R10
  ack_set_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_ack && cfg_en && !evt_token) |=> status_q[0]);
  // R11
  tok_clear_chk: assert property (@(posedge clk) disable iff (rst)
    evt_token |=> (status_q == 16'h0000));
  // R13
  rd_status_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_addr |=> (reg_rdata == $past(status_q)));
endmodule

bind ep_xact_recorder ep_xact_recorder_chk u_chk (
  .clk(clk), .rst(rst), .cfg_en(cfg_en), .evt_token(evt_token), .evt_rx(evt_rx),
  .rx_crc_bad(rx_crc_bad), .rx_pid_bad(rx_pid_bad), .evt_ack(evt_ack),
  .reg_we(reg_we), .reg_addr(reg_addr), .rx_accept(rx_accept),
  .tmo_expire(tmo_expire), .status_q(status_q), .reg_rdata(reg_rdata)
);

// File: tb/ep_xact_recorder_tb.sv
module ep_xact_recorder_tb;
  localparam int CNT_W = 10;
  localparam int TO    = 24;

  logic clk = 0, rst = 1;
  logic cfg_en = 0, cfg_dir = 0, cfg_arm = 0;
  logic [CNT_W-1:0] cfg_count = '0, rx_len = '0;
  logic evt_token = 0, evt_rx = 0, rx_data1 = 0, rx_crc_bad = 0, rx_pid_bad = 0;
  logic evt_tx_done = 0, evt_ack = 0, reg_we = 0, reg_addr = 0;
  logic [1:0]  tok_kind = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;

  int checks = 0, failures = 0;
  logic [15:0] exp_res = 0;
  logic [15:0] v;

  always #5 clk = ~clk;

  ep_xact_recorder #(.CNT_W(CNT_W), .TO_CYCLES(TO)) u_dut (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic a, output logic [15:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
    reg_addr = 0;
  endtask

  task automatic token(input logic [1:0] k);
    @(negedge clk); evt_token = 1; tok_kind = k;
    @(negedge clk); evt_token = 0;
  endtask

  task automatic pkt(input logic d1, input logic crc, input logic pid, input logic [CNT_W-1:0] len);
    @(negedge clk); evt_rx = 1; rx_data1 = d1; rx_crc_bad = crc; rx_pid_bad = pid; rx_len = len;
    @(negedge clk); evt_rx = 0; rx_crc_bad = 0; rx_pid_bad = 0;
  endtask

  task automatic pulse_ack;
    @(negedge clk); evt_ack = 1;
    @(negedge clk); evt_ack = 0;
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0; reg_addr = 0;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // expected status after one transaction, from R1..R7, R10, R11
  function automatic logic [15:0] exp_st(input logic en, arm, dir, input logic [1:0] k,
      input logic d1, crc, pid, input logic [CNT_W-1:0] len, cnt, input logic ack);
    logic [15:0] s = 16'h0;
    logic acc = en && (k == 2'd2 || (k == 2'd0 && arm && !dir));
    if (acc && k != 2'd1) begin
      s[1] = crc | pid;
      s[3] = d1;
      if (k == 2'd2) s[4] = !(crc | pid);
      else begin
        s[9]  = (len != cnt);
        s[11] = (len > cnt);
        s[10] = (len < cnt);
      end
    end
    if (ack && en) s[0] = 1;
    return s;
  endfunction

  initial begin
    int wd = 0;
    while (wd < 150000) begin @(posedge clk); wd++; end
    failures++;
    $display("FAIL watchdog actual=%0d expected=done", wd);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [1:0] k;
    logic d1, crc, pid, ack;
    logic [CNT_W-1:0] cnt, len;
    void'($urandom(32'd2024));
    wait_cyc(3);
    rst = 0;
    // R13 reset state
    rd(0, v); chk("R13 reset status", v, 16'h0);
    rd(1, v); chk("R13 reset result", v, 16'h0);

    // random transactions: R1..R7, R10, R11, R4 results
    for (int it = 0; it < 60; it++) begin
      cfg_en  = ($urandom % 4) != 0;
      cfg_arm = ($urandom % 4) != 0;
      cfg_dir = ($urandom % 3) == 0;
      cnt = CNT_W'(3 + $urandom % 1000);
      cfg_count = cnt;
      k   = 2'($urandom % 3);
      d1  = 1'($urandom);
      crc = ($urandom % 5) == 0;
      pid = ($urandom % 7) == 0;
      len = CNT_W'(int'(cnt) + int'($urandom % 7) - 3);
      ack = 1'($urandom);
      token(k);
      if (k != 2'd1) pkt(d1, crc, pid, len);
      if (ack) pulse_ack();
      if (cfg_en && k == 2'd0 && cfg_arm && !cfg_dir)
        exp_res = 16'(cnt) - 16'(len);
      rd(0, v); chk("R1-R7 status random (R1 R2 R3 R5 R6 R7 R10 R11)", v,
                    exp_st(cfg_en, cfg_arm, cfg_dir, k, d1, crc, pid, len, cnt, ack));
      rd(1, v); chk("R4 result random", v, exp_res);
    end

    // R4 overflow: negative result, R3 overflow bits
    cfg_en = 1; cfg_arm = 1; cfg_dir = 0; cfg_count = 10;
    token(0); pkt(0, 0, 0, 14);
    rd(0, v); chk("R3 overflow flags", v, 16'h0A00);
    rd(1, v); chk("R4 negative result", v, 16'hFFFC);
    // R2 crc-free mismatch leaves error clear, R12 W1C only clears chosen bit
    wr(0, 16'h0200);
    rd(0, v); chk("R12 w1c length exc only", v, 16'h0800);

    // R12 collision: W1C of error in same cycle as crc-bad packet
    token(0);
    @(negedge clk); evt_rx = 1; rx_crc_bad = 1; rx_len = 10; rx_data1 = 1;
    reg_we = 1; reg_addr = 0; reg_wdata = 16'h0002;
    @(negedge clk); evt_rx = 0; rx_crc_bad = 0; reg_we = 0;
    rd(0, v); chk("R12 hw set beats w1c (R1)", v, 16'h000A);
    // R12 result write collides with accepted packet
    token(0);
    @(negedge clk); evt_rx = 1; rx_len = 7; reg_we = 1; reg_addr = 1; reg_wdata = 16'h1234;
    @(negedge clk); evt_rx = 0; reg_we = 0; reg_addr = 0;
    rd(1, v); chk("R12 hw result beats write", v, 16'h0003);
    wr(1, 16'h1234);
    rd(1, v); chk("R12 result write", v, 16'h1234);

    // R7 disabled endpoint ignores packet
    token(0); pkt(0, 0, 0, 12);
    cfg_en = 0; pkt(1, 1, 0, 3);
    rd(0, v); chk("R7 disabled keeps status", v, 16'h0A00);
    rd(1, v); chk("R7 disabled keeps result", v, 16'hFFFE);
    // R7 unarmed OUT ignored
    cfg_en = 1; cfg_arm = 0; token(0); pkt(1, 1, 0, 3);
    rd(0, v); chk("R7 unarmed OUT ignored", v, 16'h0000);

    // R6 setup accepted with arm=0 and dir=1, no length effect
    cfg_arm = 0; cfg_dir = 1; token(2); pkt(0, 0, 0, 8);
    rd(0, v); chk("R6 setup accepted", v, 16'h0010);
    rd(1, v); chk("R6 setup leaves result", v, 16'hFFFE);

    // R9 OUT data-stage timeout
    cfg_arm = 1; cfg_dir = 0; token(0);
    wait_cyc(TO - 3);
    rd(0, v); chk("R9 no timeout before window", v, 16'h0000);
    wait_cyc(3);
    rd(0, v); chk("R9 OUT timeout", v, 16'h0004);

    // R8 IN handshake timeout
    cfg_dir = 1; token(1);
    @(negedge clk); evt_tx_done = 1; @(negedge clk); evt_tx_done = 0;
    wait_cyc(TO + 1);
    rd(0, v); chk("R8 IN timeout", v, 16'h0004);
    // R10 ack stops timer
    token(1);
    @(negedge clk); evt_tx_done = 1; @(negedge clk); evt_tx_done = 0;
    wait_cyc(5); pulse_ack(); wait_cyc(TO + 2);
    rd(0, v); chk("R10 ack without timeout", v, 16'h0001);
    // R11 token during running window clears and stops it
    token(1);
    @(negedge clk); evt_tx_done = 1; @(negedge clk); evt_tx_done = 0;
    wait_cyc(4); token(3); wait_cyc(TO + 2);
    rd(0, v); chk("R11 token clears and stops window", v, 16'h0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule